// File: doc/BRIEF.md
# Chip-Select Bank Address Decoder

This block turns each system-bus access address into a single active chip select for one of eight external device banks. Every bank owns one 32-bit window register. The register holds a base address at 128 KiB granularity, a per-bit compare mask over the upper fifteen address bits, and an enable bit. A small memory-mapped configuration port writes these registers and reads them back. The decoder reports the chip select, or a no-hit flag, one clock after the access strobe.

A strap pin is captured while reset is held. When the strap is set, the first two chip selects change places, and bank 0's enable bit reads back clear after reset so that software can see the swap. The first two banks also have a legacy capture rule. While either of their registers holds all zeros, every access goes to bank 0's chip select and no other bank can be reached. Software writes all ones into an unused bank 0 or 1 to release this capture.

Top module: `csd_decoder`

## Requirements
- R1: Bank n's window register is at configuration byte offset 0x100 + 0x10·n (n = 0..7) and reads back all 32 bits through `cfg_rdata`. Any other offset reads as zero, and a write to it changes no register.
- R2: After reset, banks 1 to 7 read 0x00000000. Bank 0 reads 0x00000001 when the strap was low during reset and 0x00000000 when it was high.
- R3: A bank matches an address when its bit 0 (enable) is set and, for every k in 1..15 where register bit k is set, address bit k+16 equals register bit k+16. Register bits 31:17 are the base. A bank with bit 0 clear never matches, except under R8.
- R4: When several enabled banks match, only the lowest-numbered one is selected, and `cs` is never more than one-hot.
- R5: A valid access that no bank matches asserts `no_hit` with `cs` all zero. A cycle without a valid access gives `cs` = 0 and `no_hit` = 0.
- R6: `cs` and `no_hit` are registered and reflect the access presented in the previous clock cycle.
- R7: The strap is captured while `rst_n` is low and is held constant until the next reset. When it is captured high, the bank 0 and bank 1 selections drive `cs[1]` and `cs[0]` respectively. All other banks keep their own chip select.
- R8: While the bank 0 or bank 1 register equals 0x00000000, every valid access selects bank 0's chip select (`cs` = 0x01 without swap, 0x02 with swap), whatever the enable bits say.
- R9: With 0xFFFFFFFF in both bank 0 and bank 1, the capture of R8 is released. Each of those banks then matches only addresses 0xFFFE0000 to 0xFFFFFFFF.
- R10: A register write is used by an access presented in the clock cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap_strap | input | 1 | Swap strap, captured during reset |
| acc_valid | input | 1 | Access address is valid this cycle |
| acc_addr | input | 32 | Access byte address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| cs | output | 8 | One-hot chip selects |
| no_hit | output | 1 | Previous access matched no bank |

## Verification
The decoder is driven with several address patterns. Addresses inside and just outside a full-mask 128 KiB window show that the mask bits line up with the right address bits. Two overlapping windows with masks of different widths show that the lower bank wins in the overlap and that the wider bank is still reachable outside it. A disabled window, a zero-mask catch-everything window and the all-ones top window cover enable handling and R9. The capture rule of R8 is tried at reset, and again right after a bank 1 register is zeroed, which also checks R10. All of this is repeated after a reset with the strap high, so the swapped mapping is separated from the plain one.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int unsigned CSD_WIN_W   = 32;
  localparam int unsigned CSD_GRAN_LO = 17;
  localparam int unsigned CSD_MASK_W  = CSD_WIN_W - CSD_GRAN_LO;

  // Window match: enable bit plus masked compare of the upper address bits.
  function automatic logic csd_window_hit(input logic [CSD_WIN_W-1:0] addr,
                                          input logic [CSD_WIN_W-1:0] win);
    logic [CSD_MASK_W-1:0] diff;
    diff = (addr[CSD_WIN_W-1:CSD_GRAN_LO] ^ win[CSD_WIN_W-1:CSD_GRAN_LO])
           & win[CSD_MASK_W:1];
    return win[0] && (diff == '0);
  endfunction

  // Configuration byte offset of bank n.
  function automatic int unsigned csd_bank_offset(input int unsigned n,
                                                  input int unsigned base,
                                                  input int unsigned stride);
    return base + n * stride;
  endfunction
endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned CFG_AW      = 12,
  parameter int unsigned BANK_BASE   = 'h100,
  parameter int unsigned BANK_STRIDE = 'h10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 strap,
  input  logic                                 wr,
  input  logic [CFG_AW-1:0]                    addr,
  input  logic [CSD_WIN_W-1:0]                 wdata,
  output logic [CSD_WIN_W-1:0]                 rdata,
  output logic [NUM_BANKS-1:0][CSD_WIN_W-1:0]  win,
  output logic                                 swap
);
  logic [NUM_BANKS-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n) swap <= strap;
  end

  generate
    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
      localparam int unsigned OFS = csd_bank_offset(n, BANK_BASE, BANK_STRIDE);
      assign sel[n] = (addr == CFG_AW'(OFS));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          if (n == 0) win[n] <= {{(CSD_WIN_W-1){1'b0}}, ~strap};
          else        win[n] <= '0;
        end else if (wr && sel[n]) begin
          win[n] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NUM_BANKS; n++) begin
      if (sel[n]) rdata = rdata | win[n];
    end
  end
endmodule

// File: rtl/csd_match.sv
module csd_match
  import csd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [NUM_BANKS-1:0][CSD_WIN_W-1:0] win,
  input  logic                                swap,
  input  logic [CSD_WIN_W-1:0]                addr,
  output logic [NUM_BANKS-1:0]                cs_sel,
  output logic                                catch_all,
  output logic                                any_hit
);
  logic [NUM_BANKS-1:0] raw_hit;
  logic [NUM_BANKS-1:0] grant;
  logic [NUM_BANKS-1:0] logical_sel;

  generate
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
      assign raw_hit[i] = csd_window_hit(addr, win[i]);
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (raw_hit[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign catch_all = (win[0] == '0) || (win[1] == '0);

  always_comb begin
    logical_sel = grant;
    if (catch_all) logical_sel = NUM_BANKS'(1);
  end

  always_comb begin
    cs_sel = logical_sel;
    if (swap) begin
      cs_sel[0] = logical_sel[1];
      cs_sel[1] = logical_sel[0];
    end
  end

  assign any_hit = |logical_sel;
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
  import csd_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned CFG_AW      = 12,
  parameter int unsigned BANK_BASE   = 'h100,
  parameter int unsigned BANK_STRIDE = 'h10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  boot_swap_strap,
  input  logic                  acc_valid,
  input  logic [31:0]           acc_addr,
  input  logic                  cfg_wr,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  output logic [NUM_BANKS-1:0]  cs,
  output logic                  no_hit
);
  logic [NUM_BANKS-1:0][CSD_WIN_W-1:0] win;
  logic                                swap_q;
  logic [NUM_BANKS-1:0]                cs_next;
  logic                                catch_all;
  logic                                any_hit;

  csd_regs #(
    .NUM_BANKS(NUM_BANKS), .CFG_AW(CFG_AW),
    .BANK_BASE(BANK_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(boot_swap_strap),
    .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .win(win), .swap(swap_q)
  );

  csd_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .win(win), .swap(swap_q), .addr(acc_addr),
    .cs_sel(cs_next), .catch_all(catch_all), .any_hit(any_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs     <= '0;
      no_hit <= 1'b0;
    end else begin
      cs     <= acc_valid ? cs_next : '0;
      no_hit <= acc_valid && !any_hit;
    end
  end
endmodule

// File: rtl/csd_checker.sv
module csd_checker #(
  parameter int unsigned NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic [NUM_BANKS-1:0] cs,
  input logic                 no_hit,
  input logic                 catch_all,
  input logic                 swap_q
);
  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  assert_hit_or_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (($countones(cs) == 1) != no_hit));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (cs == '0) && !no_hit);

  assert_strap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(swap_q));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && catch_all) |=>
      (cs == (swap_q ? NUM_BANKS'(2) : NUM_BANKS'(1))));
endmodule

bind csd_decoder csd_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .cs(cs),
  .no_hit(no_hit), .catch_all(catch_all), .swap_q(swap_q)
);

// File: tb/sim_csd_decoder.sv
module sim_csd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  cs;
  logic        no_hit;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [8];
  logic        m_swap;

  typedef struct { logic [7:0] cs; logic miss; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  csd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_swap_strap(strap),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cs(cs), .no_hit(no_hit)
  );

  // Reference: bit-by-bit compare of address bits 31..17 under the mask.
  function automatic exp_t predict(input logic [31:0] a, input string tag);
    exp_t e;
    int   win;
    e.tag = tag; e.cs = '0; e.miss = 1'b0; win = -1;
    if (m[0] == 32'h0 || m[1] == 32'h0) win = 0;
    else begin
      for (int i = 7; i >= 0; i--) begin
        bit ok;
        ok = m[i][0];
        for (int b = 17; b <= 31; b++)
          if (m[i][b-16] && (a[b] != m[i][b])) ok = 0;
        if (ok) win = i;
      end
    end
    if (win < 0) e.miss = 1'b1;
    else if (m_swap && win < 2) e.cs[1-win] = 1'b1;
    else e.cs[win] = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: one result per driven cycle, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(cs == e.cs && no_hit == e.miss, e.tag,
              {55'd0, no_hit, cs}, {55'd0, e.miss, e.cs});
      end
    end
  end

  task automatic access(input logic [31:0] a, input string tag);
    @(negedge clk);
    cfg_wr = 1'b0; acc_valid = 1'b1; acc_addr = a;
    q.push_back(predict(a, tag));
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr = 1'b0; acc_valid = 1'b0;
    e.cs = '0; e.miss = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b0; cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = d;
    e.cs = '0; e.miss = 1'b0; e.tag = "R6 idle during write";
    q.push_back(e);
    if (ofs >= 12'h100 && ofs <= 12'h170 && ofs[3:0] == 4'h0)
      m[(ofs - 12'h100) >> 4] = d;
  endtask

  task automatic rd(input logic [11:0] ofs, input logic [31:0] exp_v, input string tag);
    idle("R6 idle during read");
    cfg_addr = ofs;
    #1;
    check(cfg_rdata == exp_v, tag, {32'd0, cfg_rdata}, {32'd0, exp_v});
  endtask

  task automatic do_reset(input logic s);
    repeat (3) @(negedge clk);
    acc_valid = 1'b0; cfg_wr = 1'b0; strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    strap = ~s;
    rst_n = 1'b1;
    m_swap = s;
    m[0] = s ? 32'h0 : 32'h1;
    for (int i = 1; i < 8; i++) m[i] = '0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    rd(12'h100, 32'h1, "R2 bank0 reset no swap");
    rd(12'h110, 32'h0, "R2 bank1 reset");
    rd(12'h170, 32'h0, "R2 bank7 reset");
    access(32'h4000_0000, "R8 capture at reset");
    access(32'hFFFF_0000, "R8 capture at reset high address");
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    wr(12'h120, 32'h4000_FFFF);
    rd(12'h120, 32'h4000_FFFF, "R1 bank2 readback");
    access(32'h4001_2345, "R3 inside full-mask window");
    access(32'h4002_0000, "R5 just above window");
    access(32'h3FFF_FFFC, "R5 just below window");
    wr(12'h130, 32'h8000_F000);
    access(32'h8123_4567, "R3 disabled bank ignored");
    wr(12'h130, 32'h8000_F001);
    access(32'h8123_4567, "R3 enabled bank");
    wr(12'h140, 32'h8000_E001);
    access(32'h8FFF_0000, "R4 lower bank wins overlap");
    access(32'h9000_0000, "R4 wider bank outside overlap");
    access(32'hFFFF_0000, "R9 bank0 top window");
    access(32'hFFFD_0000, "R9 below top window");
    idle("R6 idle cycle");
    wr(12'h170, 32'h0000_0001);
    access(32'h1234_0000, "R3 zero mask bank7 catches");
    wr(12'h104, 32'hDEAD_BEEF);
    rd(12'h104, 32'h0, "R1 unmapped offset reads zero");
    rd(12'h100, 32'hFFFF_FFFF, "R1 unmapped write ignored");
    wr(12'h110, 32'h0);
    access(32'h4000_0000, "R10 write seen next cycle R8");
    wr(12'h110, 32'hFFFF_FFFF);
    access(32'h4000_0000, "R10 release seen next cycle");

    do_reset(1'b1);
    rd(12'h100, 32'h0, "R2 bank0 reset with swap");
    access(32'h4000_0000, "R7 R8 capture with swap");
    wr(12'h100, 32'h4000_FFFF);
    wr(12'h110, 32'hFFFF_FFFF);
    access(32'h4000_0000, "R7 bank0 drives cs1");
    access(32'hFFFF_0000, "R7 bank1 drives cs0");
    wr(12'h150, 32'h6000_FFFF);
    access(32'h6000_0000, "R7 other banks unchanged");
    idle("R6 drain");
    idle("R6 drain");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule